// File: doc/BRIEF.md
# Oversampling UART Receiver with Majority Vote and Noise Flag

This block receives an asynchronous serial byte stream. The serial line passes through a two-flop synchronizer and is then sampled once per pulse of an external sample tick. The tick runs at 16 or 8 times the bit rate. Every bit, including the start and stop bits, is decided by a majority of three samples taken at the middle of the bit. When those three samples do not all agree, the frame is marked noisy. A noisy frame is still delivered.

The frame has one start bit (0), eight data bits with the least significant bit first, and one stop bit (1). The line idles at 1. A falling edge on the line begins a frame. The start bit must then be confirmed by its own mid-bit vote. On a good stop bit, the assembled byte moves into the receive data register and the ready flag rises. If noise occurred anywhere in that frame, the noise flag rises in the same cycle. The ready flag clears when the data is read. The noise flag is sticky until it is cleared by a pulse. The error interrupt reports the noise flag, but only in multibuffer mode with the enable set. Asserting a special-mode input forces 16x sampling, whatever oversampling is requested.

Top module: `nvrx_top`

## Requirements
- R1: After reset, rx_ready, noise_flag and err_irq are 0 and rx_data is 0x00.
- R2: With 16x sampling, each bit is decided from samples 8, 9 and 10 of its 16 samples. The tick on which a 0 follows a 1 counts as sample 1 of the start bit. A byte sent as start 0, eight data bits LSB first, then stop 1 appears on rx_data with rx_ready set.
- R3: With 8x sampling (ovs8_req=1, special_mode=0), each bit is decided from samples 4, 5 and 6 of its 8 samples, and bytes are received correctly.
- R4: The bit value is the majority of its three window samples. Written in time order, the patterns 000, 001, 010 and 100 give 0, and 011, 101, 110 and 111 give 1.
- R5: Any window pattern other than 000 or 111, in any bit of the frame, marks the frame as noisy. A sample outside the three-sample window has no effect on the bit value or on noise.
- R6: noise_flag rises in the same cycle as rx_ready for a noisy frame. The noisy byte is still written to rx_data. rx_data changes only when a frame is accepted.
- R7: noise_flag stays set until a noise_clr pulse. If a noisy frame completes in the same cycle as noise_clr, the flag stays set.
- R8: A rd_strobe pulse clears rx_ready.
- R9: err_irq is 1 only while noise_flag=1, multibuf_mode=1 and err_irq_en=1. In single-byte mode (multibuf_mode=0), noise never raises it.
- R10: While special_mode=1, a frame is sampled at 16x even when ovs8_req=1.
- R11: If the mid-bit vote of the start bit gives 1, the receiver returns to idle with no data transfer. It then accepts the next valid frame.
- R12: If the stop-bit vote gives 0, the frame is dropped. rx_ready and rx_data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle 1 |
| sample_tick | input | 1 | One-cycle pulse per oversample period |
| ovs8_req | input | 1 | Request 8x oversampling (else 16x) |
| special_mode | input | 1 | Forces 16x oversampling when 1 |
| multibuf_mode | input | 1 | Multibuffer mode, lets noise reach err_irq |
| err_irq_en | input | 1 | Error interrupt enable |
| rd_strobe | input | 1 | Pulse: receive data register read |
| noise_clr | input | 1 | Pulse: clear noise_flag |
| rx_data | output | 8 | Receive data register |
| rx_ready | output | 1 | Receive data ready |
| noise_flag | output | 1 | Sticky noise flag |
| err_irq | output | 1 | Error interrupt |

## Verification
Two events can land in the same clock cycle: a noisy frame's stop-bit decision, which sets noise_flag, and a software noise_clr pulse. The bench places noise_clr exactly on the tick that carries the stop bit's third window sample. It then requires noise_flag to read 1 afterwards. In the same run, the bench records the cycle in which rx_ready rises and the cycle in which noise_flag rises, and requires the two to be equal.

// File: rtl/nvrx_pkg.sv
// Package: shared types and the three-sample vote helpers for the receiver.
// Assumes samples are supplied in time order (first, second, third).
package nvrx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // Majority of three samples
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // True when the three samples do not all agree
    function automatic logic mixed3(input logic a, input logic b, input logic c);
        return !((a == b) && (b == c));
    endfunction

endpackage

// File: rtl/nvrx_sync.sv
// Module: multi-stage synchronizer bringing an asynchronous line into clk.
// Assumes the line idles at IDLE_VAL; reset loads that value into every stage.
module nvrx_sync #(
    parameter int  STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{IDLE_VAL}};
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/nvrx_sampler.sv
// Module: per-bit sample counter and mid-bit three-sample voting window.
// Assumes start pulses on the tick that is sample 1 of the start bit and
// run stays high for the rest of the frame. Produces one decision per bit,
// on the tick that carries the third window sample.
module nvrx_sampler
    import nvrx_pkg::*;
#(
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic run,
    input  logic ovs8,
    input  logic din,
    output logic bit_done,
    output logic bit_val,
    output logic bit_noise
);
    localparam int CW     = $clog2(OVS_HI + 1);
    localparam int MID_HI = OVS_HI / 2 + 1;
    localparam int MID_LO = OVS_LO / 2 + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] idx_now;
    logic [CW-1:0] n_lim;
    logic [CW-1:0] mid;
    logic          s_first;
    logic          s_second;

    // Select bit length and window centre for the current rate
    always_comb begin
        n_lim = ovs8 ? CW'(OVS_LO) : CW'(OVS_HI);
        mid   = ovs8 ? CW'(MID_LO) : CW'(MID_HI);
    end

    // Index of the sample taken on this tick
    assign idx_now = (cnt == n_lim) ? CW'(1) : cnt + CW'(1);

    // Track sample index within the bit
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (tick) begin
            if (start)        cnt <= CW'(1);
            else if (run)     cnt <= idx_now;
        end
    end

    // Capture the first two window samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_first  <= 1'b1;
            s_second <= 1'b1;
        end else if (tick && run && !start) begin
            if (idx_now == mid - CW'(1)) s_first  <= din;
            if (idx_now == mid)          s_second <= din;
        end
    end

    // Decide on the third window sample
    always_comb begin
        bit_done  = tick && run && !start && (idx_now == mid + CW'(1));
        bit_val   = maj3(s_first, s_second, din);
        bit_noise = mixed3(s_first, s_second, din);
    end
endmodule

// File: rtl/nvrx_ctrl.sv
// Module: frame sequencer. Detects the start edge, confirms the start bit,
// assembles data LSB first, checks the stop bit, and accumulates frame noise.
// Assumes one bit decision per bit from the sampler; the rate is latched
// at the start edge so it cannot change mid-frame.
module nvrx_ctrl
    import nvrx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          din,
    input  logic          ovs8_eff,
    input  logic          bit_done,
    input  logic          bit_val,
    input  logic          bit_noise,
    output logic          run,
    output logic          start_det,
    output logic          ovs8_q,
    output logic          xfer,
    output logic [DW-1:0] xdata,
    output logic          xnoise
);
    localparam int BCW = $clog2(DW);

    rx_state_t      state;
    logic           prev_s;
    logic [BCW-1:0] bit_idx;
    logic [DW-1:0]  shreg;
    logic           frame_noise;

    // Falling edge seen on a sample tick while idle
    assign start_det = tick && (state == RX_IDLE) && prev_s && !din;
    assign run       = (state != RX_IDLE);

    // Remember the previous sampled line level
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_s <= 1'b1;
        else if (tick) prev_s <= din;
    end

    // Latch the effective rate at frame start
    always_ff @(posedge clk) begin
        if (!rst_n)         ovs8_q <= 1'b0;
        else if (start_det) ovs8_q <= ovs8_eff;
    end

    // Frame state machine with shift register and noise accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            bit_idx     <= '0;
            shreg       <= '0;
            frame_noise <= 1'b0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    if (start_det) begin
                        state       <= RX_START;
                        frame_noise <= 1'b0;
                    end
                end
                RX_START: begin
                    if (bit_done) begin
                        if (bit_val) begin
                            state <= RX_IDLE;
                        end else begin
                            state       <= RX_DATA;
                            bit_idx     <= '0;
                            frame_noise <= frame_noise | bit_noise;
                        end
                    end
                end
                RX_DATA: begin
                    if (bit_done) begin
                        shreg       <= {bit_val, shreg[DW-1:1]};
                        frame_noise <= frame_noise | bit_noise;
                        if (bit_idx == BCW'(DW - 1)) state <= RX_STOP;
                        else                         bit_idx <= bit_idx + BCW'(1);
                    end
                end
                RX_STOP: begin
                    if (bit_done) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Hand the frame over on a good stop bit
    always_comb begin
        xfer   = (state == RX_STOP) && bit_done && bit_val;
        xdata  = shreg;
        xnoise = frame_noise | bit_noise;
    end
endmodule

// File: rtl/nvrx_flags.sv
// Module: receive data register, ready and noise flags, error interrupt.
// Assumes xfer is a one-cycle pulse; a set in the same cycle as a clear wins.
module nvrx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer,
    input  logic [DW-1:0] xdata,
    input  logic          xnoise,
    input  logic          rd_strobe,
    input  logic          noise_clr,
    input  logic          multibuf_mode,
    input  logic          err_irq_en,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          noise_flag,
    output logic          err_irq
);
    // Load the data register on each accepted frame
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_data <= '0;
        else if (xfer) rx_data <= xdata;
    end

    // Ready flag: set by a transfer, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_ready <= 1'b0;
        else if (xfer)      rx_ready <= 1'b1;
        else if (rd_strobe) rx_ready <= 1'b0;
    end

    // Sticky noise flag: set with ready, cleared by a pulse
    always_ff @(posedge clk) begin
        if (!rst_n)              noise_flag <= 1'b0;
        else if (xfer && xnoise) noise_flag <= 1'b1;
        else if (noise_clr)      noise_flag <= 1'b0;
    end

    // Noise interrupts only in multibuffer mode with the enable set
    assign err_irq = noise_flag && multibuf_mode && err_irq_en;
endmodule

// File: rtl/nvrx_top.sv
// Module: oversampling UART receiver top. Synchronizes the line, votes each
// bit from three mid-bit samples, sequences frames and keeps the flags.
// Assumes sample_tick pulses at OVS_HI or OVS_LO times the bit rate.
module nvrx_top
    import nvrx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int OVS_HI   = 16,
    parameter int OVS_LO   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_line,
    input  logic          sample_tick,
    input  logic          ovs8_req,
    input  logic          special_mode,
    input  logic          multibuf_mode,
    input  logic          err_irq_en,
    input  logic          rd_strobe,
    input  logic          noise_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          noise_flag,
    output logic          err_irq
);
    logic          din;
    logic          ovs8_eff;
    logic          run;
    logic          start_det;
    logic          ovs8_q;
    logic          bit_done;
    logic          bit_val;
    logic          bit_noise;
    logic          xfer;
    logic [DW-1:0] xdata;
    logic          xnoise;

    // Special modes force 16x sampling
    assign ovs8_eff = ovs8_req && !special_mode;

    nvrx_sync #(.STAGES(SYNC_STG), .IDLE_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_line),
        .sync_out (din)
    );

    nvrx_sampler #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .start     (start_det),
        .run       (run),
        .ovs8      (ovs8_q),
        .din       (din),
        .bit_done  (bit_done),
        .bit_val   (bit_val),
        .bit_noise (bit_noise)
    );

    nvrx_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .din       (din),
        .ovs8_eff  (ovs8_eff),
        .bit_done  (bit_done),
        .bit_val   (bit_val),
        .bit_noise (bit_noise),
        .run       (run),
        .start_det (start_det),
        .ovs8_q    (ovs8_q),
        .xfer      (xfer),
        .xdata     (xdata),
        .xnoise    (xnoise)
    );

    nvrx_flags #(.DW(DW)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer          (xfer),
        .xdata         (xdata),
        .xnoise        (xnoise),
        .rd_strobe     (rd_strobe),
        .noise_clr     (noise_clr),
        .multibuf_mode (multibuf_mode),
        .err_irq_en    (err_irq_en),
        .rx_data       (rx_data),
        .rx_ready      (rx_ready),
        .noise_flag    (noise_flag),
        .err_irq       (err_irq)
    );
endmodule

// File: rtl/nvrx_chk.sv
// Checker: temporal properties of the receiver, bound into nvrx_top.
// Assumes it sees the top's ports plus the internal transfer and rate signals.
module nvrx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          special_mode,
    input logic          multibuf_mode,
    input logic          err_irq_en,
    input logic          rd_strobe,
    input logic          noise_clr,
    input logic [DW-1:0] rx_data,
    input logic          rx_ready,
    input logic          noise_flag,
    input logic          err_irq,
    input logic          xfer,
    input logic          start_det,
    input logic          ovs8_q
);
    assert_xfer_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> rx_ready);

    assert_noise_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_flag) |-> $past(xfer));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(rx_data));

    assert_noise_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_flag && !noise_clr) |=> noise_flag);

    assert_noise_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_clr && !xfer) |=> !noise_flag);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !xfer) |=> !rx_ready);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(multibuf_mode && err_irq_en) |-> !err_irq);

    assert_force_x16_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && special_mode) |=> !ovs8_q);
endmodule

bind nvrx_top nvrx_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .special_mode  (special_mode),
    .multibuf_mode (multibuf_mode),
    .err_irq_en    (err_irq_en),
    .rd_strobe     (rd_strobe),
    .noise_clr     (noise_clr),
    .rx_data       (rx_data),
    .rx_ready      (rx_ready),
    .noise_flag    (noise_flag),
    .err_irq       (err_irq),
    .xfer          (xfer),
    .start_det     (start_det),
    .ovs8_q        (ovs8_q)
);

// File: tb/nvrx_top_test.sv
module nvrx_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       sample_tick = 1'b0;
    logic       ovs8_req = 1'b0;
    logic       special_mode = 1'b0;
    logic       multibuf_mode = 1'b0;
    logic       err_irq_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       noise_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       noise_flag;
    logic       err_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int cyc = 0;
    int rdy_rise = -1;
    int nz_rise = -2;
    logic rdy_d = 1'b0;
    logic nz_d = 1'b0;
    int tdiv = 0;

    always #2.5 clk = ~clk;

    nvrx_top uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .sample_tick(sample_tick),
        .ovs8_req(ovs8_req), .special_mode(special_mode),
        .multibuf_mode(multibuf_mode), .err_irq_en(err_irq_en),
        .rd_strobe(rd_strobe), .noise_clr(noise_clr), .rx_data(rx_data),
        .rx_ready(rx_ready), .noise_flag(noise_flag), .err_irq(err_irq)
    );

    // Tick generator: one pulse every 4 clocks
    always @(posedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        sample_tick <= (tdiv == 2);
    end

    // Record the cycles in which ready and noise rise
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rx_ready && !rdy_d) rdy_rise = cyc;
        if (noise_flag && !nz_d) nz_rise = cyc;
        rdy_d = rx_ready;
        nz_d = noise_flag;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic vote(input logic [2:0] p);
        return (p[2] & p[1]) | (p[2] & p[0]) | (p[1] & p[0]);
    endfunction

    task automatic align();
        @(negedge clk);
        while (!sample_tick) @(negedge clk);
        @(negedge clk);
    endtask

    // Present one sample; it is taken on the next tick
    task automatic put(input logic v, input bit clr);
        rx_line = v;
        @(negedge clk);
        while (!sample_tick) @(negedge clk);
        noise_clr = clr;
        @(negedge clk);
        noise_clr = 1'b0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) put(1'b1, 1'b0);
    endtask

    // One bit of n samples; window pattern and glitch position optional
    task automatic send_bit(input logic val, input int n, input bit usepat,
                            input logic [2:0] pat, input int gpos, input bit clr);
        int mid;
        mid = n / 2 + 1;
        for (int s = 1; s <= n; s++) begin
            logic v;
            v = val;
            if (usepat && s == mid - 1) v = pat[2];
            if (usepat && s == mid)     v = pat[1];
            if (usepat && s == mid + 1) v = pat[0];
            if (s == gpos) v = ~val;
            put(v, clr && (s == mid + 1));
        end
    endtask

    // Frame: bit 0 start, 1..8 data, 9 stop; nbit selects the altered bit
    task automatic send_frame(input logic [7:0] d, input int n, input int nbit,
                              input bit usepat, input logic [2:0] pat,
                              input int gpos, input bit clr_stop, input bit bad_stop);
        align();
        idle(2);
        for (int b = 0; b < 10; b++) begin
            logic v;
            if (b == 0)      v = 1'b0;
            else if (b == 9) v = !bad_stop;
            else             v = d[b-1];
            send_bit(v, n, usepat && (b == nbit), pat,
                     (b == nbit) ? gpos : 0, clr_stop && (b == 9));
        end
        idle(3);
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); noise_clr = 1'b1;
        @(negedge clk); noise_clr = 1'b0;
    endtask

    task automatic t_reset();
        check(rx_ready == 0, "R1 ready", rx_ready, 0);
        check(noise_flag == 0, "R1 noise", noise_flag, 0);
        check(err_irq == 0, "R1 irq", err_irq, 0);
        check(rx_data == 8'h00, "R1 data", rx_data, 0);
    endtask

    task automatic t_x16_clean();
        send_frame(8'hA5, 16, -1, 0, 3'b000, 0, 0, 0);
        check(rx_data == 8'hA5, "R2 data x16", rx_data, 8'hA5);
        check(rx_ready == 1, "R2 ready", rx_ready, 1);
        check(noise_flag == 0, "R2 no noise", noise_flag, 0);
        do_read();
        check(rx_ready == 0, "R8 read clears", rx_ready, 0);
    endtask

    task automatic t_x8_clean();
        ovs8_req = 1'b1;
        send_frame(8'h3C, 8, -1, 0, 3'b000, 0, 0, 0);
        check(rx_data == 8'h3C, "R3 data x8", rx_data, 8'h3C);
        check(rx_ready == 1, "R3 ready", rx_ready, 1);
        do_read();
        send_frame(8'hFF, 8, 4, 1, 3'b100, 0, 0, 0);
        check(rx_data == {4'hF, 1'b0, 3'b111}, "R4 pattern 100 x8", rx_data, 8'hF7);
        check(noise_flag == 1, "R5 noise x8", noise_flag, 1);
        do_read();
        do_clear();
        ovs8_req = 1'b0;
    endtask

    task automatic t_majority_sticky();
        logic [7:0] e;
        e = 8'h5A;
        e[0] = vote(3'b011);
        send_frame(8'h5A, 16, 1, 1, 3'b011, 0, 0, 0);
        check(rx_data == e, "R4 pattern 011", rx_data, e);
        check(noise_flag == 1, "R5 noise set", noise_flag, 1);
        check(nz_rise == rdy_rise, "R6 same cycle", nz_rise, rdy_rise);
        do_read();
        send_frame(8'h11, 16, -1, 0, 3'b000, 0, 0, 0);
        check(rx_data == 8'h11, "R6 later data", rx_data, 8'h11);
        check(noise_flag == 1, "R7 sticky", noise_flag, 1);
        do_clear();
        check(noise_flag == 0, "R7 cleared", noise_flag, 0);
        do_read();
    endtask

    task automatic t_glitch_outside();
        send_frame(8'h00, 16, 3, 0, 3'b000, 3, 0, 0);
        check(rx_data == 8'h00, "R5 glitch data", rx_data, 0);
        check(noise_flag == 0, "R5 glitch no noise", noise_flag, 0);
        do_read();
    endtask

    task automatic t_irq();
        multibuf_mode = 1'b0;
        err_irq_en = 1'b1;
        send_frame(8'h81, 16, 9, 1, 3'b110, 0, 0, 0);
        check(noise_flag == 1, "R5 stop-bit noise", noise_flag, 1);
        check(err_irq == 0, "R9 single-byte", err_irq, 0);
        multibuf_mode = 1'b1;
        #1;
        check(err_irq == 1, "R9 multibuf", err_irq, 1);
        err_irq_en = 1'b0;
        #1;
        check(err_irq == 0, "R9 disabled", err_irq, 0);
        err_irq_en = 1'b1;
        do_clear();
        check(err_irq == 0, "R9 after clear", err_irq, 0);
        multibuf_mode = 1'b0;
        err_irq_en = 1'b0;
        do_read();
    endtask

    task automatic t_collision();
        send_frame(8'h77, 16, 5, 1, 3'b010, 0, 1, 0);
        check(noise_flag == 1, "R7 set beats clear", noise_flag, 1);
        check(rx_data == 8'h67, "R4 pattern 010", rx_data, 8'h67);
        check(nz_rise == rdy_rise, "R6 same cycle 2", nz_rise, rdy_rise);
        do_clear();
        do_read();
    endtask

    task automatic t_special();
        ovs8_req = 1'b1;
        special_mode = 1'b1;
        send_frame(8'hC3, 16, -1, 0, 3'b000, 0, 0, 0);
        check(rx_data == 8'hC3, "R10 forced x16", rx_data, 8'hC3);
        check(rx_ready == 1, "R10 ready", rx_ready, 1);
        ovs8_req = 1'b0;
        special_mode = 1'b0;
        do_read();
    endtask

    task automatic t_false_start();
        align();
        idle(2);
        for (int s = 1; s <= 16; s++) put((s <= 3) ? 1'b0 : 1'b1, 1'b0);
        idle(20);
        check(rx_ready == 0, "R11 no transfer", rx_ready, 0);
        check(rx_data == 8'hC3, "R11 data kept", rx_data, 8'hC3);
        send_frame(8'h96, 16, -1, 0, 3'b000, 0, 0, 0);
        check(rx_data == 8'h96, "R11 next frame", rx_data, 8'h96);
        do_read();
    endtask

    task automatic t_bad_stop();
        send_frame(8'h24, 16, -1, 0, 3'b000, 0, 0, 1);
        idle(16);
        check(rx_ready == 0, "R12 no ready", rx_ready, 0);
        check(rx_data == 8'h96, "R12 data kept", rx_data, 8'h96);
        send_frame(8'h42, 16, -1, 0, 3'b000, 0, 0, 0);
        check(rx_data == 8'h42, "R12 recovery", rx_data, 8'h42);
        do_read();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_x16_clean();
        t_x8_clean();
        t_majority_sticky();
        t_glitch_outside();
        t_irq();
        t_collision();
        t_special();
        t_false_start();
        t_bad_stop();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule